// File: doc/BRIEF.md
# Single-Cycle Instruction Decode Sequencer

This block fetches one 64-bit instruction word per clock from a word-addressed program memory and runs it to completion in that same cycle. Each word holds three 16-bit operand fields: a destination register, a first source register and a second source register. The low 16 bits hold a type field. The type field is split into a duplication count, a 4-bit variant and a 4-bit opcode. The sequencer executes the control opcodes itself: the timed sleep, jumps through a register, the 32-bit immediate load, the data memory load and store, and the compare against zero. It sends every other opcode to an external execute port, which returns a result and a "supported" flag in the same cycle.

A small register file has two read ports and one write port. It holds 64-bit values. The low bits of each 16-bit register field select the register. The data memory port takes a 24-bit word address. Writes commit on the clock edge and read data is returned within the cycle. Surrounding logic supplies the program memory, the data memory and the arithmetic units.

Top module: `wseq_core`

## Requirements
- R1: Word layout: destination index in bits [63:48], first source in [47:32], second source in [31:16], duplication count in [15:8] (ignored), variant in [7:4], opcode in [3:0]. A register is selected by the low log2(REGS) bits of its 16-bit field.
- R2: Opcode 0 holds the program counter for imm+1 cycles, where imm is bits [47:16]. During that time no store, no execute request and no register write occurs. An all-zero word takes exactly one cycle.
- R3: Opcode 1, variant 0, loads the program counter from the low bits of the destination register when the first source register is nonzero. Otherwise the counter advances.
- R4: Opcode 1, variant 1, always jumps to the destination register value. Any other variant of opcode 1 only advances the counter.
- R5: Opcode 2 writes bits [47:16], zero-extended to 64 bits, into the destination register.
- R6: Opcode 3 addresses data memory with the low 24 bits of the first source register. Variant 0 loads the destination register and variant 1 stores it. Both take one cycle.
- R7: Opcode 4 writes 1 or 0 to the destination register. Variant 0 tests the first source for zero. Variant 1 tests it for being negative as a signed value. Any other variant writes nothing.
- R8: Opcodes 5 to 15 raise ex_valid for one cycle and present the first and second source values, the opcode and the variant. When ex_ok is high, ex_result is written to the destination register.
- R9: When ex_ok is low for an execute request, no register changes and the instruction behaves as a one-cycle no-op.
- R10: A synchronous active-high reset sets the program counter to 0 and ends any sleep.
- R11: Every instruction that is not a jump taken, a sleep, or a sleep cycle other than the last advances the program counter by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Program word index (program counter) |
| imem_data | input | 64 | Instruction word at imem_addr |
| dmem_addr | output | 24 | Data memory word address |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 64 | Data memory write value |
| dmem_rdata | input | 64 | Data memory read value for dmem_addr |
| ex_valid | output | 1 | Execute request |
| ex_opc | output | 4 | Opcode presented to the execute unit |
| ex_vrt | output | 4 | Variant presented to the execute unit |
| ex_a | output | 64 | First source register value |
| ex_b | output | 64 | Second source register value |
| ex_result | input | 64 | Result from the execute unit |
| ex_ok | input | 1 | Execute unit supports the requested operation |

## Verification
Register contents can only be observed through stores and execute operands. The hardest case is a conditional jump taken on a flag that was built from a value which had already passed through data memory. The program builds this chain: an immediate feeds an execute add, the sum is stored and reloaded, then subtracted and compared, and the compare result steers a jump past an instruction that would have overwritten a register stored later. The program also puts a multi-cycle sleep and an all-zero word in line with normal instructions. A behavioural reference model checks the program counter and every memory and execute strobe on each cycle.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
    localparam int WORD_W  = 64;
    localparam int FIELD_W = 16;
    localparam int IMM_W   = 32;
    localparam int DADDR_W = 24;

    localparam logic [3:0] OPC_NAP = 4'd0;
    localparam logic [3:0] OPC_BR  = 4'd1;
    localparam logic [3:0] OPC_IMM = 4'd2;
    localparam logic [3:0] OPC_MEM = 4'd3;
    localparam logic [3:0] OPC_TST = 4'd4;

    typedef struct packed {
        logic [FIELD_W-1:0] dst;
        logic [FIELD_W-1:0] src_a;
        logic [FIELD_W-1:0] src_b;
        logic [7:0]         dup;
        logic [3:0]         vrt;
        logic [3:0]         opc;
    } instr_t;

    typedef enum logic [2:0] {
        WB_NONE,
        WB_IMM,
        WB_LOAD,
        WB_IS_ZERO,
        WB_IS_NEG,
        WB_EXEC
    } wb_src_e;

    typedef enum logic [1:0] {
        BR_NONE,
        BR_IF_NZ,
        BR_ALWAYS
    } br_e;

    typedef struct packed {
        wb_src_e wb;
        br_e     br;
        logic    st;
        logic    exe;
        logic    nap;
        logic    b_is_src_b;
    } ctrl_t;

    function automatic logic [IMM_W-1:0] imm_of(instr_t i);
        return {i.src_a, i.src_b};
    endfunction
endpackage

// File: rtl/wseq_decode.sv
module wseq_decode
    import wseq_pkg::*;
(
    input  instr_t ins,
    input  logic   busy,
    output ctrl_t  ctl
);
    logic unused_dec;
    assign unused_dec = ^{ins.dst, ins.dup};

    always_comb begin
        ctl            = '0;
        ctl.wb         = WB_NONE;
        ctl.br         = BR_NONE;
        ctl.b_is_src_b = 1'b0;
        if (!busy) begin
            unique case (ins.opc)
                OPC_NAP: ctl.nap = (imm_of(ins) != '0);
                OPC_BR: begin
                    if (ins.vrt == 4'd0)      ctl.br = BR_IF_NZ;
                    else if (ins.vrt == 4'd1) ctl.br = BR_ALWAYS;
                end
                OPC_IMM: ctl.wb = WB_IMM;
                OPC_MEM: begin
                    if (ins.vrt == 4'd0)      ctl.wb = WB_LOAD;
                    else if (ins.vrt == 4'd1) ctl.st = 1'b1;
                end
                OPC_TST: begin
                    if (ins.vrt == 4'd0)      ctl.wb = WB_IS_ZERO;
                    else if (ins.vrt == 4'd1) ctl.wb = WB_IS_NEG;
                end
                default: begin
                    ctl.exe        = 1'b1;
                    ctl.wb         = WB_EXEC;
                    ctl.b_is_src_b = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/wseq_regfile.sv
module wseq_regfile #(
    parameter int REGS = 16,
    parameter int W    = 64,
    localparam int IW  = $clog2(REGS)
) (
    input  logic          clk,
    input  logic [IW-1:0] ra_idx,
    input  logic [IW-1:0] rb_idx,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);
    logic [W-1:0] cells [REGS];

    always_ff @(posedge clk) begin
        if (we) cells[wa] <= wd;
    end

    assign rd_a = cells[ra_idx];
    assign rd_b = cells[rb_idx];
endmodule

// File: rtl/wseq_sleep.sv
module wseq_sleep #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] count,
    output logic          busy,
    output logic          last
);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)       remain <= '0;
        else if (busy) remain <= remain - CW'(1);
        else if (load) remain <= count;
    end

    assign busy = (remain != '0);
    assign last = (remain == CW'(1));
endmodule

// File: rtl/wseq_core.sv
module wseq_core
    import wseq_pkg::*;
#(
    parameter int PC_W = 10,
    parameter int REGS = 16,
    localparam int IW  = $clog2(REGS)
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [WORD_W-1:0]  imem_data,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic               dmem_we,
    output logic [WORD_W-1:0]  dmem_wdata,
    input  logic [WORD_W-1:0]  dmem_rdata,
    output logic               ex_valid,
    output logic [3:0]         ex_opc,
    output logic [3:0]         ex_vrt,
    output logic [WORD_W-1:0]  ex_a,
    output logic [WORD_W-1:0]  ex_b,
    input  logic [WORD_W-1:0]  ex_result,
    input  logic               ex_ok
);
    instr_t            ins;
    ctrl_t             ctl;
    logic [PC_W-1:0]   pc;
    logic [PC_W-1:0]   pc_next;
    logic              slp_busy;
    logic              slp_last;
    logic [3:0]        cur_opc;
    logic [WORD_W-1:0] rd_a;
    logic [WORD_W-1:0] rd_b;
    logic [IW-1:0]     rb_idx;
    logic              wb_en;
    logic [WORD_W-1:0] wb_data;
    logic              br_take;

    assign ins     = instr_t'(imem_data);
    assign cur_opc = ins.opc;

    wseq_decode u_dec (
        .ins  (ins),
        .busy (slp_busy),
        .ctl  (ctl)
    );

    assign rb_idx = ctl.b_is_src_b ? ins.src_b[IW-1:0] : ins.dst[IW-1:0];

    wseq_regfile #(.REGS(REGS), .W(WORD_W)) u_rf (
        .clk    (clk),
        .ra_idx (ins.src_a[IW-1:0]),
        .rb_idx (rb_idx),
        .we     (wb_en),
        .wa     (ins.dst[IW-1:0]),
        .wd     (wb_data),
        .rd_a   (rd_a),
        .rd_b   (rd_b)
    );

    wseq_sleep #(.CW(IMM_W)) u_slp (
        .clk   (clk),
        .rst   (rst),
        .load  (ctl.nap),
        .count (imm_of(ins)),
        .busy  (slp_busy),
        .last  (slp_last)
    );

    always_comb begin
        wb_en   = 1'b1;
        wb_data = '0;
        unique case (ctl.wb)
            WB_IMM:     wb_data = WORD_W'(imm_of(ins));
            WB_LOAD:    wb_data = dmem_rdata;
            WB_IS_ZERO: wb_data = WORD_W'(rd_a == '0);
            WB_IS_NEG:  wb_data = WORD_W'(rd_a[WORD_W-1]);
            WB_EXEC: begin
                wb_data = ex_result;
                wb_en   = ex_ok;
            end
            default:    wb_en = 1'b0;
        endcase
    end

    always_comb begin
        unique case (ctl.br)
            BR_IF_NZ:  br_take = (rd_a != '0);
            BR_ALWAYS: br_take = 1'b1;
            default:   br_take = 1'b0;
        endcase
    end

    always_comb begin
        if (slp_busy)      pc_next = slp_last ? pc + PC_W'(1) : pc;
        else if (br_take)  pc_next = rd_b[PC_W-1:0];
        else if (ctl.nap)  pc_next = pc;
        else               pc_next = pc + PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    assign imem_addr  = pc;
    assign dmem_addr  = rd_a[DADDR_W-1:0];
    assign dmem_we    = ctl.st;
    assign dmem_wdata = rd_b;
    assign ex_valid   = ctl.exe;
    assign ex_opc     = ins.opc;
    assign ex_vrt     = ins.vrt;
    assign ex_a       = rd_a;
    assign ex_b       = rd_b;
endmodule

// File: rtl/wseq_checker.sv
module wseq_checker #(
    parameter int PC_W = 10
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] pc,
    input logic            dmem_we,
    input logic            ex_valid,
    input logic            busy,
    input logic            last,
    input logic [3:0]      opc
);
    p_reset_pc_r10: assert property (@(posedge clk)
        $past(rst) |-> pc == '0);

    p_sleep_hold_r2: assert property (@(posedge clk) disable iff (rst)
        busy && !last |=> $stable(pc));

    p_sleep_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> !dmem_we && !ex_valid);

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dmem_we, ex_valid}));

    p_pc_step_r11: assert property (@(posedge clk) disable iff (rst)
        !busy && opc == 4'd2 |=> pc == $past(pc) + PC_W'(1));

    p_store_step_r6: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> pc == $past(pc) + PC_W'(1));
endmodule

bind wseq_core wseq_checker #(.PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (imem_addr),
    .dmem_we  (dmem_we),
    .ex_valid (ex_valid),
    .busy     (slp_busy),
    .last     (slp_last),
    .opc      (cur_opc)
);

// File: tb/wseq_core_bench.sv
module wseq_core_bench;
    localparam int PC_W = 10;
    localparam int NPROG = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [PC_W-1:0] imem_addr;
    logic [63:0] imem_data;
    logic [23:0] dmem_addr;
    logic        dmem_we;
    logic [63:0] dmem_wdata;
    logic [63:0] dmem_rdata;
    logic        ex_valid;
    logic [3:0]  ex_opc;
    logic [3:0]  ex_vrt;
    logic [63:0] ex_a;
    logic [63:0] ex_b;
    logic [63:0] ex_result;
    logic        ex_ok;

    logic [63:0] prog [NPROG];
    logic [63:0] bmem [256];
    logic [63:0] m_regs [16];
    logic [63:0] m_mem [256];
    int unsigned m_pc;
    longint unsigned m_cnt;
    int checks = 0;
    int errors = 0;
    bit done = 0;
    int at3 = 0;
    int at16 = 0;

    always #5 clk = ~clk;

    wseq_core #(.PC_W(PC_W), .REGS(16)) u_wseq_core (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .ex_valid(ex_valid), .ex_opc(ex_opc),
        .ex_vrt(ex_vrt), .ex_a(ex_a), .ex_b(ex_b), .ex_result(ex_result),
        .ex_ok(ex_ok)
    );

    // Bench execute unit: op5 v0 add, op5 v2 sub, op6 v7 or; all else unsupported
    function automatic logic [64:0] xu(logic [3:0] o, logic [3:0] v, logic [63:0] a, logic [63:0] b);
        if (o == 4'd5 && v == 4'd0) return {1'b1, a + b};
        if (o == 4'd5 && v == 4'd2) return {1'b1, a - b};
        if (o == 4'd6 && v == 4'd7) return {1'b1, a | b};
        return {1'b0, 64'h0};
    endfunction

    always_comb begin
        logic [64:0] r;
        r = xu(ex_opc, ex_vrt, ex_a, ex_b);
        ex_ok     = r[64];
        ex_result = r[63:0];
    end

    assign imem_data  = (imem_addr < PC_W'(NPROG)) ? prog[imem_addr] : 64'h0;
    assign dmem_rdata = bmem[dmem_addr[7:0]];

    always_ff @(posedge clk) begin
        if (dmem_we) bmem[dmem_addr[7:0]] <= dmem_wdata;
    end

    function automatic logic [63:0] mk(logic [15:0] x, logic [15:0] y, logic [15:0] z,
                                       logic [7:0] d, logic [3:0] v, logic [3:0] o);
        return {x, y, z, d, v, o};
    endfunction

    function automatic logic [63:0] mki(logic [15:0] x, logic [31:0] imm, logic [3:0] o);
        return {x, imm, 8'h00, 4'h0, o};
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(logic [3:0] o);
        case (o)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R5";
            4'd3: return "R6";
            4'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Compare this cycle's outputs with the model, then advance the model one clock
    task automatic step_model();
        logic [63:0] w;
        logic [3:0] o, v, x, y, z;
        logic [31:0] imm;
        logic [64:0] r;
        bit exp_we, exp_ev;
        string tg;
        chk(imem_addr == PC_W'(m_pc), "R11 pc", 64'(imem_addr), 64'(m_pc));
        if (imem_addr == PC_W'(3)) at3++;
        if (imem_addr == PC_W'(16)) at16++;
        w = prog[m_pc];
        o = w[3:0]; v = w[7:4]; x = w[51:48]; y = w[35:32]; z = w[19:16];
        imm = w[47:16];
        tg = tag_of(o);
        exp_we = 0; exp_ev = 0;
        if (m_cnt != 0) begin
            chk(!dmem_we && !ex_valid, "R2 quiet", {62'h0, dmem_we, ex_valid}, 64'h0);
            if (m_cnt == 1) m_pc++;
            m_cnt--;
            return;
        end
        case (o)
            4'd0: begin
                if (imm != 0) m_cnt = imm; else m_pc++;
            end
            4'd1: begin
                if ((v == 0 && m_regs[y] != 0) || v == 1) m_pc = int'(m_regs[x][PC_W-1:0]);
                else m_pc++;
            end
            4'd2: begin m_regs[x] = {32'h0, imm}; m_pc++; end
            4'd3: begin
                chk(dmem_addr == m_regs[y][23:0], "R6 addr", 64'(dmem_addr), 64'(m_regs[y][23:0]));
                if (v == 0) m_regs[x] = m_mem[m_regs[y][7:0]];
                else if (v == 1) begin
                    exp_we = 1;
                    chk(dmem_wdata == m_regs[x], "R6 wdata", dmem_wdata, m_regs[x]);
                    m_mem[m_regs[y][7:0]] = m_regs[x];
                end
                m_pc++;
            end
            4'd4: begin
                if (v == 0) m_regs[x] = 64'(m_regs[y] == 0);
                else if (v == 1) m_regs[x] = 64'(m_regs[y][63]);
                m_pc++;
            end
            default: begin
                exp_ev = 1;
                chk(ex_a == m_regs[y], "R8 ex_a", ex_a, m_regs[y]);
                chk(ex_b == m_regs[z], "R8 ex_b", ex_b, m_regs[z]);
                chk(ex_opc == o && ex_vrt == v, "R8 opc", {56'h0, ex_opc, ex_vrt}, {56'h0, o, v});
                r = xu(o, v, m_regs[y], m_regs[z]);
                if (r[64]) m_regs[x] = r[63:0];
                m_pc++;
            end
        endcase
        chk(dmem_we == exp_we, {tg, " we"}, 64'(dmem_we), 64'(exp_we));
        chk(ex_valid == exp_ev, {tg, " ex_valid"}, 64'(ex_valid), 64'(exp_ev));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin bmem[i] = '0; m_mem[i] = '0; end
        for (int i = 0; i < 16; i++) m_regs[i] = '0;
        for (int i = 0; i < NPROG; i++) prog[i] = '0;
        prog[0]  = mki(16'd0, 32'd0, 4'd2);
        prog[1]  = mki(16'd1, 32'd5, 4'd2);
        prog[2]  = mki(16'd2, 32'hFFFF_FFFF, 4'd2);            // R5 zero-extension
        prog[3]  = mki(16'd0, 32'd3, 4'd0);                    // R2 sleep 4 cycles
        prog[4]  = mk(16'h0013, 16'd1, 16'd2, 8'h07, 4'd0, 4'd5); // R1 upper index bits, dup ignored
        prog[5]  = mk(16'd3, 16'd1, 16'd0, 8'h00, 4'd1, 4'd3);
        prog[6]  = mk(16'd4, 16'd1, 16'd0, 8'h00, 4'd0, 4'd3);
        prog[7]  = mk(16'd5, 16'd0, 16'd4, 8'h00, 4'd2, 4'd5);
        prog[8]  = mk(16'd6, 16'd5, 16'd0, 8'h00, 4'd1, 4'd4);
        prog[9]  = mk(16'd7, 16'd1, 16'd0, 8'h00, 4'd0, 4'd4);
        prog[10] = mki(16'd8, 32'h0100_0010, 4'd2);
        prog[11] = mk(16'd6, 16'd8, 16'd0, 8'h00, 4'd1, 4'd3);  // R6 24-bit address
        prog[12] = mki(16'd9, 32'd17, 4'd2);
        prog[13] = mk(16'd7, 16'd9, 16'd0, 8'h00, 4'd1, 4'd3);
        prog[14] = mk(16'd6, 16'd1, 16'd1, 8'h00, 4'd0, 4'd7);  // R9 unsupported
        prog[15] = mk(16'd1, 16'd0, 16'd0, 8'h00, 4'd2, 4'd4);  // R7 other variant
        prog[16] = 64'h0;                                      // R2 one-cycle word
        prog[17] = mki(16'd10, 32'd21, 4'd2);
        prog[18] = mk(16'd10, 16'd7, 16'd0, 8'h00, 4'd0, 4'd1); // R3 not taken
        prog[19] = mk(16'd10, 16'd6, 16'd0, 8'h00, 4'd0, 4'd1); // R3 taken
        prog[20] = mki(16'd1, 32'h99, 4'd2);
        prog[21] = mk(16'd1, 16'd0, 16'd0, 8'h00, 4'd1, 4'd3);
        prog[22] = mki(16'd11, 32'd24, 4'd2);
        prog[23] = mk(16'd11, 16'd7, 16'd0, 8'h00, 4'd1, 4'd1); // R4
        prog[24] = mk(16'd11, 16'd6, 16'd0, 8'h00, 4'd3, 4'd1); // R4 other variant
        prog[25] = mk(16'd13, 16'd1, 16'd4, 8'h00, 4'd7, 4'd6);
        prog[26] = mk(16'd13, 16'd9, 16'd0, 8'h00, 4'd1, 4'd3);
        prog[27] = mki(16'd12, 32'd28, 4'd2);
        prog[28] = mk(16'd12, 16'd0, 16'd0, 8'h00, 4'd1, 4'd1);

        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(imem_addr == '0, "R10 reset pc", 64'(imem_addr), 64'h0);
        chk(!dmem_we && !ex_valid, "R10 reset strobes", {62'h0, dmem_we, ex_valid}, 64'h0);
        rst = 1'b0;
        m_pc = 0;
        m_cnt = 0;
        for (int c = 0; c < 60; c++) begin
            step_model();
            @(negedge clk);
        end
        chk(at3 == 4, "R2 sleep length", 64'(at3), 64'd4);
        chk(at16 == 1, "R2 zero word", 64'(at16), 64'd1);
        chk(bmem[5] == 64'h1_0000_0004, "R5 R8 sum", bmem[5], 64'h1_0000_0004);
        chk(bmem[16] == 64'd1, "R7 R6 neg flag", bmem[16], 64'd1);
        chk(bmem[0] == 64'd5, "R9 R7 R3 kept", bmem[0], 64'd5);
        chk(bmem[17] == 64'h1_0000_0005, "R8 or", bmem[17], 64'h1_0000_0005);
        chk(imem_addr == PC_W'(28), "R4 halt loop", 64'(imem_addr), 64'd28);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(imem_addr == '0, "R10 re-reset", 64'(imem_addr), 64'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule